// File: doc/BRIEF.md
# Receive Descriptor Ring Index Manager

This block keeps the indexes of a circular ring of receive descriptors that a host and a device share. The device reports, through a closed index, how far it has filled the ring. The host consumes entries one at a time with a processed pulse, and the block moves its read index along behind that pulse. On a restock trigger it draws buffer addresses from a free pool, checks them, and writes each good one into the descriptor slot at the write index. It then publishes a device-visible write pointer that only moves in steps of eight slots. When the free pool runs low it raises a replenish request.

A restock starts in one of three ways. The host can request one. One also runs when the read index catches up with the closed index. In burst mode, one runs after every eight processed entries. Burst mode begins when a closed-index update shows that more than half the ring is waiting to be refilled. The fill sequencer has four states. From `ST_IDLE` it goes to `ST_TAKE` when a trigger is pending. `ST_TAKE` pops one pool entry and goes to `ST_SETTLE` if there is space and the pool is not empty; otherwise it goes to `ST_PUBLISH`. `ST_SETTLE` always returns to `ST_TAKE`, which gives the pool head one cycle to advance. `ST_PUBLISH` updates the published pointer and the replenish request and returns to `ST_IDLE`.

Top module: `rx_ring_indexer`

## Requirements
- R1: After reset the read index, write index and published pointer are 0, and the error flag, replenish request, descriptor write strobe and publish pulse are all low.
- R2: `space` equals (read - write) mod depth, taken as depth when that difference is 0, minus 2, with a floor of 0. With the default depth of 256, read 0 and write 5 give 249.
- R3: A fill writes no descriptor while `space` is 0. From reset, with an ample pool, the write index stops at depth-2.
- R4: Each accepted pool entry is written at the current write index with data equal to address bits [35:8]. The write index then advances by one and wraps at the depth. The fill also stops when the pool count is 0.
- R5: The published pointer equals the write index with its low 3 bits cleared. It is refreshed at the end of each fill, and `pub_upd` pulses for one cycle only when its value changes.
- R6: `closed_idx` is reduced to its low 12 bits, and then to the index width. A processed pulse advances the read index only while the read index differs from the closed index.
- R7: A pool address with any of bits [7:0] set, or any bit at or above bit 36 set, is popped but not written. The write index does not move, and `addr_err` rises and stays high until reset.
- R8: At the end of each fill, `replenish_req` is set to (pool count <= 8).
- R9: When a processed pulse brings the read index up to the closed index, a fill runs.
- R10: Burst mode begins when (closed - published pointer) mod depth exceeds depth/2 at a closed-index update. In burst mode a fill runs after every 8 processed entries.
- R11: A `restock_go` pulse starts a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| closed_vld | input | 1 | Closed index update strobe |
| closed_idx | input | 16 | Closed index reported by the device |
| proc_pulse | input | 1 | Host has processed one entry |
| restock_go | input | 1 | Host restock request |
| pool_cnt | input | 10 | Number of buffers in the free pool |
| pool_addr | input | 40 | Address at the head of the free pool |
| pool_pop | output | 1 | Head of the pool is consumed this cycle |
| desc_we | output | 1 | Descriptor write strobe |
| desc_idx | output | 8 | Descriptor slot being written |
| desc_data | output | 28 | Descriptor value (address >> 8) |
| pub_wptr | output | 8 | Device-visible write pointer |
| pub_upd | output | 1 | Published pointer changed |
| replenish_req | output | 1 | Free pool is at or below the watermark |
| addr_err | output | 1 | Sticky bad-address flag |
| rd_idx | output | 8 | Host read (processed) index |
| wr_idx | output | 8 | Internal write index |
| space | output | 9 | Free slots available to fill |

## Verification
The bench fills the ring from reset until the two reserved slots stop it. A design that confuses full with empty would either write past depth-2 or write nothing. It places an unaligned address in the pool and checks both the skipped slot and the sticky flag. A faulty check would shift every later descriptor or drop the flag. It also sends a closed index with upper bits set, and checks that processing stops exactly at the masked value and that an extra pulse leaves the read index in place. Finally it compares a burst-mode batch with a normal one: after eight processed entries only the burst case refills, and a wrong half-ring comparison shows up as a write index that does not move.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TAKE    = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_PUBLISH = 2'd3
    } fill_state_t;
endpackage

// File: rtl/ring_space.sv
module ring_space #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W:0]   space
);
    localparam logic [IDX_W:0] DEPTH = (IDX_W+1)'(1) << IDX_W;
    localparam logic [IDX_W:0] GUARD = (IDX_W+1)'(2);

    logic [IDX_W-1:0] gap;
    logic [IDX_W:0]   span;

    always_comb begin
        gap   = rd_idx - wr_idx;
        span  = (gap == '0) ? DEPTH : {1'b0, gap};
        space = (span >= GUARD) ? (span - GUARD) : '0;
    end

    // R2: space never exceeds depth minus the two guard slots
    always_comb begin
        a_r2_space_bound: assert (space <= DEPTH - GUARD);
    end
endmodule

// File: rtl/addr_check.sv
module addr_check #(
    parameter int IN_W   = 40,
    parameter int MAX_W  = 36,
    parameter int ALIGN  = 8
) (
    input  logic [IN_W-1:0]        addr,
    output logic                   addr_ok,
    output logic [MAX_W-ALIGN-1:0] desc_val
);
    logic low_clear;
    logic high_clear;

    assign low_clear = (addr[ALIGN-1:0] == '0);
    assign desc_val  = addr[MAX_W-1:ALIGN];

    generate
        if (IN_W > MAX_W) begin : g_wide
            assign high_clear = (addr[IN_W-1:MAX_W] == '0);
        end else begin : g_fit
            assign high_clear = 1'b1;
        end
    endgenerate

    assign addr_ok = low_clear && high_clear;
endmodule

// File: rtl/ring_reader_track.sv
module ring_reader_track #(
    parameter int IDX_W       = 8,
    parameter int CLOSED_W    = 16,
    parameter int CLOSED_KEEP = 12,
    parameter int BURST_LEN   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                closed_vld,
    input  logic [CLOSED_W-1:0] closed_idx,
    input  logic                proc_pulse,
    input  logic [IDX_W-1:0]    pub_wptr,
    output logic [IDX_W-1:0]    rd_idx,
    output logic                trig
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURST_LEN - 1);
    localparam logic [IDX_W-1:0] HALF = IDX_W'(1) << (IDX_W - 1);
    localparam logic [CLOSED_W-1:0] KEEP_MASK = CLOSED_W'((64'd1 << CLOSED_KEEP) - 64'd1);

    logic [CLOSED_W-1:0] kept;
    logic [IDX_W-1:0]    closed_new;
    logic [IDX_W-1:0]    waiting;
    logic [IDX_W-1:0]    rd_q;
    logic [IDX_W-1:0]    closed_q;
    logic                burst_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                accept;
    logic                reach_end;

    always_comb begin
        kept       = closed_idx & KEEP_MASK;
        closed_new = kept[IDX_W-1:0];
        waiting    = closed_new - pub_wptr;
        accept     = proc_pulse && (rd_q != closed_q);
        reach_end  = accept && ((rd_q + 1'b1) == closed_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= '0;
            closed_q <= '0;
            burst_q  <= 1'b0;
            cnt_q    <= '0;
            trig     <= 1'b0;
        end else begin
            trig <= 1'b0;
            if (closed_vld) begin
                closed_q <= closed_new;
                burst_q  <= (waiting > HALF);
                cnt_q    <= '0;
            end else if (accept) begin
                rd_q <= rd_q + 1'b1;
                if (reach_end) begin
                    trig    <= 1'b1;
                    burst_q <= 1'b0;
                    cnt_q   <= '0;
                end else if (burst_q) begin
                    if (cnt_q == CNT_LAST) begin
                        trig  <= 1'b1;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign rd_idx = rd_q;

    // R6: a processed pulse at the closed index leaves the read index alone
    a_r6_hold_at_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_pulse && !closed_vld && rd_q == closed_q) |=> $stable(rd_q));

    // R9: reaching the closed index always requests a fill
    a_r9_end_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (reach_end && !closed_vld) |=> trig);
endmodule

// File: rtl/rx_ring_indexer.sv
module rx_ring_indexer
    import rx_ring_pkg::*;
#(
    parameter int RING_DEPTH    = 256,
    parameter int ADDR_IN_W     = 40,
    parameter int ADDR_MAX_W    = 36,
    parameter int ALIGN_LOG2    = 8,
    parameter int POOL_W        = 10,
    parameter int LOW_MARK      = 8,
    parameter int BURST_LEN     = 8,
    parameter int PUB_STEP_LOG2 = 3,
    parameter int CLOSED_W      = 16,
    parameter int CLOSED_KEEP   = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                closed_vld,
    input  logic [CLOSED_W-1:0]                 closed_idx,
    input  logic                                proc_pulse,
    input  logic                                restock_go,
    input  logic [POOL_W-1:0]                   pool_cnt,
    input  logic [ADDR_IN_W-1:0]                pool_addr,
    output logic                                pool_pop,
    output logic                                desc_we,
    output logic [$clog2(RING_DEPTH)-1:0]       desc_idx,
    output logic [ADDR_MAX_W-ALIGN_LOG2-1:0]    desc_data,
    output logic [$clog2(RING_DEPTH)-1:0]       pub_wptr,
    output logic                                pub_upd,
    output logic                                replenish_req,
    output logic                                addr_err,
    output logic [$clog2(RING_DEPTH)-1:0]       rd_idx,
    output logic [$clog2(RING_DEPTH)-1:0]       wr_idx,
    output logic [$clog2(RING_DEPTH):0]         space
);
    localparam int IDX_W = $clog2(RING_DEPTH);
    localparam int DESC_W = ADDR_MAX_W - ALIGN_LOG2;
    localparam logic [IDX_W-1:0] STEP_MASK = ~IDX_W'((1 << PUB_STEP_LOG2) - 1);
    localparam logic [POOL_W-1:0] MARK = POOL_W'(LOW_MARK);

    fill_state_t state_q, state_d;

    logic [IDX_W-1:0]  wr_q;
    logic [IDX_W-1:0]  pub_q;
    logic              pub_upd_q;
    logic              repl_q;
    logic              err_q;
    logic              pend_q;
    logic              trig;
    logic              addr_ok;
    logic [DESC_W-1:0] desc_val;
    logic [IDX_W-1:0]  rounded;
    logic              can_take;
    logic              pop_c;
    logic              we_c;
    logic              publish_c;

    ring_space #(.IDX_W(IDX_W)) u_space (
        .rd_idx (rd_idx),
        .wr_idx (wr_q),
        .space  (space)
    );

    addr_check #(
        .IN_W  (ADDR_IN_W),
        .MAX_W (ADDR_MAX_W),
        .ALIGN (ALIGN_LOG2)
    ) u_check (
        .addr     (pool_addr),
        .addr_ok  (addr_ok),
        .desc_val (desc_val)
    );

    ring_reader_track #(
        .IDX_W       (IDX_W),
        .CLOSED_W    (CLOSED_W),
        .CLOSED_KEEP (CLOSED_KEEP),
        .BURST_LEN   (BURST_LEN)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .closed_vld (closed_vld),
        .closed_idx (closed_idx),
        .proc_pulse (proc_pulse),
        .pub_wptr   (pub_q),
        .rd_idx     (rd_idx),
        .trig       (trig)
    );

    assign can_take = (space != '0) && (pool_cnt != '0);
    assign rounded  = wr_q & STEP_MASK;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and sequencer outputs
    always_comb begin
        state_d   = state_q;
        pop_c     = 1'b0;
        we_c      = 1'b0;
        publish_c = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_q) state_d = ST_TAKE;
            end
            ST_TAKE: begin
                if (can_take) begin
                    pop_c   = 1'b1;
                    we_c    = addr_ok;
                    state_d = ST_SETTLE;
                end else begin
                    state_d = ST_PUBLISH;
                end
            end
            ST_SETTLE: begin
                state_d = ST_TAKE;
            end
            ST_PUBLISH: begin
                publish_c = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= '0;
            pub_q     <= '0;
            pub_upd_q <= 1'b0;
            repl_q    <= 1'b0;
            err_q     <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            pub_upd_q <= 1'b0;
            if (state_q == ST_IDLE && pend_q)
                pend_q <= trig || restock_go;
            else if (trig || restock_go)
                pend_q <= 1'b1;
            if (we_c)
                wr_q <= wr_q + 1'b1;
            if (pop_c && !addr_ok)
                err_q <= 1'b1;
            if (publish_c) begin
                repl_q <= (pool_cnt <= MARK);
                if (rounded != pub_q) begin
                    pub_q     <= rounded;
                    pub_upd_q <= 1'b1;
                end
            end
        end
    end

    assign pool_pop      = pop_c;
    assign desc_we       = we_c;
    assign desc_idx      = wr_q;
    assign desc_data     = desc_val;
    assign pub_wptr      = pub_q;
    assign pub_upd       = pub_upd_q;
    assign replenish_req = repl_q;
    assign addr_err      = err_q;
    assign wr_idx        = wr_q;

    // R3: no descriptor is written into the guard slots
    a_r3_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> (space != '0));

    // R4: each write advances the write index by exactly one
    a_r4_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |=> (wr_q == $past(wr_q) + 1'b1));

    // R5: the published pointer is aligned and the pulse marks a real change
    a_r5_pub_change: assert property (@(posedge clk) disable iff (!rst_n)
        pub_upd |-> ((pub_q & ~STEP_MASK) == '0 && pub_q != $past(pub_q)));

    // R7: a rejected address is never written and the flag stays set
    a_r7_no_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_pop && !addr_ok) |-> !desc_we);
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);
endmodule

// File: tb/rx_ring_indexer_test.sv
module rx_ring_indexer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        closed_vld = 1'b0;
    logic [15:0] closed_idx = '0;
    logic        proc_pulse = 1'b0;
    logic        restock_go = 1'b0;
    logic [9:0]  pool_cnt = '0;
    logic [39:0] pool_addr;
    logic        pool_pop, desc_we, pub_upd, replenish_req, addr_err;
    logic [7:0]  desc_idx, pub_wptr, rd_idx, wr_idx;
    logic [27:0] desc_data;
    logic [8:0]  space;

    int checks = 0;
    int fails = 0;
    int pool_k = 0;
    int bad_k = -1;
    int exp_wr = 0;
    int upd_cnt = 0;
    bit pop_prev = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign pool_addr = (pool_k == bad_k) ? ((40'(pool_k + 1) << 8) | 40'h5)
                                         : (40'(pool_k + 1) << 8);

    rx_ring_indexer uut (
        .clk(clk), .rst_n(rst_n), .closed_vld(closed_vld), .closed_idx(closed_idx),
        .proc_pulse(proc_pulse), .restock_go(restock_go), .pool_cnt(pool_cnt),
        .pool_addr(pool_addr), .pool_pop(pool_pop), .desc_we(desc_we),
        .desc_idx(desc_idx), .desc_data(desc_data), .pub_wptr(pub_wptr),
        .pub_upd(pub_upd), .replenish_req(replenish_req), .addr_err(addr_err),
        .rd_idx(rd_idx), .wr_idx(wr_idx), .space(space)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pool model and descriptor monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && desc_we) begin
                check("R4 slot", int'(desc_idx), exp_wr);
                check("R4 data", int'(desc_data), pool_k + 1);
                exp_wr = (exp_wr + 1) % 256;
            end
            if (rst_n && pub_upd) upd_cnt++;
            if (pop_prev) begin
                pool_cnt = pool_cnt - 10'd1;
                pool_k++;
            end
            pop_prev = pool_pop;
        end
    end

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_restock();
        @(negedge clk); restock_go = 1'b1;
        @(negedge clk); restock_go = 1'b0;
    endtask

    task automatic process(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); proc_pulse = 1'b1;
            @(negedge clk); proc_pulse = 1'b0;
        end
    endtask

    task automatic set_closed(logic [15:0] v);
        @(negedge clk); closed_idx = v; closed_vld = 1'b1;
        @(negedge clk); closed_vld = 1'b0;
    endtask

    task automatic t_reset();
        settle(1);
        check("R1 rd", int'(rd_idx), 0);
        check("R1 wr", int'(wr_idx), 0);
        check("R1 pub", int'(pub_wptr), 0);
        check("R1 err", int'(addr_err), 0);
        check("R1 repl", int'(replenish_req), 0);
        check("R1 we", int'(desc_we), 0);
    endtask

    task automatic t_small_fill();
        upd_cnt = 0;
        @(negedge clk); pool_cnt = 10'd5;
        pulse_restock();          // R11
        settle(30);
        check("R11 wr after go", int'(wr_idx), 5);
        check("R4 pool drained", int'(pool_cnt), 0);
        check("R2 space", int'(space), 249);
        check("R5 pub held", int'(pub_wptr), 0);
        check("R5 no pulse", upd_cnt, 0);
        check("R8 low pool", int'(replenish_req), 1);
    endtask

    task automatic t_bad_addr();
        bad_k = pool_k;
        @(negedge clk); pool_cnt = 10'd2;
        pulse_restock();
        settle(20);
        check("R7 err set", int'(addr_err), 1);
        check("R7 wr one step", int'(wr_idx), 6);
        check("R7 pool both popped", int'(pool_cnt), 0);
    endtask

    task automatic t_fill_full();
        upd_cnt = 0;
        @(negedge clk); pool_cnt = 10'd300;
        pulse_restock();
        settle(560);
        check("R3 wr stops", int'(wr_idx), 254);
        check("R3 space zero", int'(space), 0);
        check("R3 pool left", int'(pool_cnt), 52);
        check("R5 pub rounded", int'(pub_wptr), 248);
        check("R5 one pulse", upd_cnt, 1);
        check("R8 pool ample", int'(replenish_req), 0);
        check("R7 err sticky", int'(addr_err), 1);
    endtask

    task automatic t_end_batch();
        upd_cnt = 0;
        set_closed(16'h0A0A);     // R6: keeps 0xA0A, index 0x0A
        process(9);
        settle(4);
        check("R9 no early fill", int'(wr_idx), 254);
        process(1);
        settle(40);
        check("R6 rd at closed", int'(rd_idx), 10);
        check("R9 wr wraps", int'(wr_idx), 8);
        check("R5 pub wrap", int'(pub_wptr), 8);
        check("R5 pulse", upd_cnt, 1);
        process(1);
        settle(10);
        check("R6 extra ignored", int'(rd_idx), 10);
        check("R6 wr unchanged", int'(wr_idx), 8);
    endtask

    task automatic t_burst();
        set_closed(16'd210);      // waiting 202 > 128: R10
        process(7);
        settle(6);
        check("R10 no fill at 7", int'(wr_idx), 8);
        process(1);
        settle(40);
        check("R10 rd", int'(rd_idx), 18);
        check("R10 fill at 8", int'(wr_idx), 16);
        check("R10 pub", int'(pub_wptr), 16);
        process(7);
        settle(20);
        check("R10 quiet between", int'(wr_idx), 16);
        check("R10 pool", int'(pool_cnt), 34);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_small_fill();
        t_bad_addr();
        t_fill_full();
        t_end_batch();
        t_burst();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule